// File: doc/BRIEF.md
# UART Register Front-End with Identification Window

This block is the programmer-visible register layer of a serial port. It decodes a 4 KB window of word-aligned, single-cycle reads and writes. It holds the configuration the serial engines need: the integer and fractional baud divisors, the infrared low-power divisor, line control, control, the FIFO level select and DMA control. It also holds the interrupt mask, the raw interrupt status and the latched receive error status. The transmitter and the receive buffer are outside the block. The block drives them through push, pop and flush strobes and reads back their fill flags and the head entry of the receive buffer.

The top eight words of the window return a read-only eight-byte identification table. A parameter picks one of two tables. When the loopback bit of the control register is set, bytes written for transmission are also placed in the receive buffer. Turning send-break on in that mode places a break marker there as well.

The block holds no state machine; all behaviour is decode plus register updates. A data read returns the receive head in the same cycle and pops it on the next clock edge.

Top module: `uart_reg_frontend`

## Requirements
- R1: An access is decoded on address bits [11:2]. Word offsets: data 0x00, receive status 0x01, flags 0x06, infrared divisor 0x08, integer divisor 0x09, fractional divisor 0x0A, line control 0x0B, control 0x0C, level select 0x0D, mask 0x0E, raw status 0x0F, masked status 0x10, interrupt clear 0x11, DMA control 0x12. An access with address bits [1:0] non-zero is treated as unmapped.
- R2: Reads of byte addresses 0xFE0 through 0xFFC return table byte (address − 0xFE0)/4. Parameter ID_VARIANT=0 selects the table 11 10 14 00 0D F0 05 B1, and ID_VARIANT=1 selects 11 00 18 01 0D F0 05 B1. Writes to this range change nothing.
- R3: Unmapped offsets read as zero and ignore writes. The interrupt-clear register reads as zero. Writes to the flag register alter no register.
- R4: After reset the level select reads 0x12. Divisors, infrared divisor, DMA control, mask, raw status, line control and control all read 0, and irq is low.
- R5: The integer divisor keeps write bits [15:0]. The fractional divisor keeps [5:0], the infrared divisor [7:0] and DMA control [2:0].
- R6: A data write pulses tx_push in the same cycle, with tx_byte equal to write bits [7:0]. It also sets raw status bit 5.
- R7: When control bit 7 (loopback) is set, a data write also pulses rx_push with rx_entry = the byte, zero-extended. With loopback clear, rx_push stays low.
- R8: A line-control write that takes bit 0 (send break) from 0 to 1 while loopback is set pulses rx_push with rx_entry 0x400. The pulse does not occur if the bit was already 1, if it is being cleared, or if loopback is off.
- R9: A line-control write that changes bit 4 (FIFO enable) pulses rx_flush in that cycle. Other writes do not.
- R10: A data read returns rx_head zero-extended in the same cycle. rx_pop pulses only when rx_empty is low. The read latches rx_head[11:8] into the receive status register, which reads in bits [3:0]. Any write to the receive status register clears it.
- R11: The flag register reads rx_empty in bit 4, tx_full in bit 5, rx_full in bit 6 and tx_empty in bit 7, and 0 elsewhere.
- R12: Mask is an 11-bit read/write register. Raw status bit 4 is set on every rx_push. Masked status reads raw AND mask, and irq is high when that value is non-zero. A write to interrupt clear clears the raw bits set in the written value.
- R13: The configuration outputs baud_int, baud_frac, line_ctrl, ctrl, fifo_lvl, irda_div and dma_ctrl equal the stored register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high, else 0 |
| tx_push | output | 1 | Pushes tx_byte into the transmitter |
| tx_byte | output | 8 | Byte for the transmitter |
| rx_push | output | 1 | Loopback push into the receive buffer |
| rx_entry | output | 12 | Entry pushed by rx_push |
| rx_flush | output | 1 | Empties the receive buffer |
| rx_pop | output | 1 | Pops the receive buffer head |
| rx_head | input | 12 | Receive buffer head entry (errors in [11:8]) |
| rx_empty | input | 1 | Receive buffer empty |
| rx_full | input | 1 | Receive buffer full |
| tx_full | input | 1 | Transmitter buffer full |
| tx_empty | input | 1 | Transmitter buffer empty |
| baud_int | output | 16 | Integer baud divisor |
| baud_frac | output | 6 | Fractional baud divisor |
| line_ctrl | output | 8 | Line control |
| ctrl | output | 16 | Control |
| fifo_lvl | output | 6 | FIFO level select |
| irda_div | output | 8 | Infrared low-power divisor |
| dma_ctrl | output | 3 | DMA control |
| irq | output | 1 | Combined interrupt |

## Verification
The decoder is exercised with aligned offsets for every register, with offsets one byte off a live register, with unused words and with the whole ID window. These patterns show whether the decode looks at the low address bits, and whether each variant's table and its index order are correct. The line-control tests cover each transition of break and FIFO enable, both with and without loopback, so a strobe triggered on level rather than on change gets caught. The data read path is run with the receive buffer both empty and non-empty, which separates gating of the pop from the latching of the error bits.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_DATA, SEL_RXSTAT, SEL_FLAG, SEL_IRDA, SEL_BINT,
        SEL_BFRAC, SEL_LINE, SEL_CTRL, SEL_LVL, SEL_MASK, SEL_RAW,
        SEL_MSTAT, SEL_CLR, SEL_DMA, SEL_ID
    } reg_sel_e;

    localparam logic [9:0] OFS_DATA   = 10'h000;
    localparam logic [9:0] OFS_RXSTAT = 10'h001;
    localparam logic [9:0] OFS_FLAG   = 10'h006;
    localparam logic [9:0] OFS_IRDA   = 10'h008;
    localparam logic [9:0] OFS_BINT   = 10'h009;
    localparam logic [9:0] OFS_BFRAC  = 10'h00A;
    localparam logic [9:0] OFS_LINE   = 10'h00B;
    localparam logic [9:0] OFS_CTRL   = 10'h00C;
    localparam logic [9:0] OFS_LVL    = 10'h00D;
    localparam logic [9:0] OFS_MASK   = 10'h00E;
    localparam logic [9:0] OFS_RAW    = 10'h00F;
    localparam logic [9:0] OFS_MSTAT  = 10'h010;
    localparam logic [9:0] OFS_CLR    = 10'h011;
    localparam logic [9:0] OFS_DMA    = 10'h012;

    localparam int LINE_BRK  = 0;
    localparam int LINE_FEN  = 4;
    localparam int CTRL_LOOP = 7;
    localparam int IRQ_RX    = 4;
    localparam int IRQ_TX    = 5;
    localparam int IRQ_W     = 11;
    localparam int BRK_BIT   = 10;

    localparam logic [5:0] LVL_RESET = 6'h12;

endpackage

// File: rtl/uart_addr_dec.sv
module uart_addr_dec
    import uart_regs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [2:0]        id_idx
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    assign word   = addr[ADDR_W-1:2];
    assign id_idx = word[2:0];

    always_comb begin
        sel = SEL_NONE;
        if (addr[1:0] == 2'b00) begin
            if (&word[WORD_W-1:3]) begin
                sel = SEL_ID;
            end else begin
                case (word)
                    WORD_W'(OFS_DATA):   sel = SEL_DATA;
                    WORD_W'(OFS_RXSTAT): sel = SEL_RXSTAT;
                    WORD_W'(OFS_FLAG):   sel = SEL_FLAG;
                    WORD_W'(OFS_IRDA):   sel = SEL_IRDA;
                    WORD_W'(OFS_BINT):   sel = SEL_BINT;
                    WORD_W'(OFS_BFRAC):  sel = SEL_BFRAC;
                    WORD_W'(OFS_LINE):   sel = SEL_LINE;
                    WORD_W'(OFS_CTRL):   sel = SEL_CTRL;
                    WORD_W'(OFS_LVL):    sel = SEL_LVL;
                    WORD_W'(OFS_MASK):   sel = SEL_MASK;
                    WORD_W'(OFS_RAW):    sel = SEL_RAW;
                    WORD_W'(OFS_MSTAT):  sel = SEL_MSTAT;
                    WORD_W'(OFS_CLR):    sel = SEL_CLR;
                    WORD_W'(OFS_DMA):    sel = SEL_DMA;
                    default:             sel = SEL_NONE;
                endcase
            end
        end
    end

    // R1: a misaligned address never selects a register
    always_comb begin
        a_r1_misaligned_none: assert (addr[1:0] == 2'b00 || sel == SEL_NONE);
    end
endmodule

// File: rtl/uart_id_rom.sv
module uart_id_rom #(
    parameter int VARIANT = 0
) (
    input  logic [2:0] idx,
    output logic [7:0] id_byte
);
    generate
        if (VARIANT == 0) begin : g_table_a
            always_comb begin
                unique case (idx)
                    3'd0: id_byte = 8'h11;
                    3'd1: id_byte = 8'h10;
                    3'd2: id_byte = 8'h14;
                    3'd3: id_byte = 8'h00;
                    3'd4: id_byte = 8'h0D;
                    3'd5: id_byte = 8'hF0;
                    3'd6: id_byte = 8'h05;
                    default: id_byte = 8'hB1;
                endcase
            end
        end else begin : g_table_b
            always_comb begin
                unique case (idx)
                    3'd0: id_byte = 8'h11;
                    3'd1: id_byte = 8'h00;
                    3'd2: id_byte = 8'h18;
                    3'd3: id_byte = 8'h01;
                    3'd4: id_byte = 8'h0D;
                    3'd5: id_byte = 8'hF0;
                    3'd6: id_byte = 8'h05;
                    default: id_byte = 8'hB1;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
    import uart_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  reg_sel_e    sel,
    input  logic [15:0] wdata,
    output logic [15:0] baud_int,
    output logic [5:0]  baud_frac,
    output logic [7:0]  line_ctrl,
    output logic [15:0] ctrl,
    output logic [5:0]  fifo_lvl,
    output logic [7:0]  irda_div,
    output logic [2:0]  dma_ctrl,
    output logic        brk_on,
    output logic        fen_flip
);
    logic line_wr;
    assign line_wr  = wr_en && (sel == SEL_LINE);
    assign brk_on   = line_wr && !line_ctrl[LINE_BRK] && wdata[LINE_BRK];
    assign fen_flip = line_wr && (line_ctrl[LINE_FEN] != wdata[LINE_FEN]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            baud_int  <= '0;
            baud_frac <= '0;
            line_ctrl <= '0;
            ctrl      <= '0;
            fifo_lvl  <= LVL_RESET;
            irda_div  <= '0;
            dma_ctrl  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_BINT:  baud_int  <= wdata;
                SEL_BFRAC: baud_frac <= wdata[5:0];
                SEL_LINE:  line_ctrl <= wdata[7:0];
                SEL_CTRL:  ctrl      <= wdata;
                SEL_LVL:   fifo_lvl  <= wdata[5:0];
                SEL_IRDA:  irda_div  <= wdata[7:0];
                SEL_DMA:   dma_ctrl  <= wdata[2:0];
                default: ;
            endcase
        end
    end

    // R5: a level-select write lands masked on the next cycle
    a_r5_lvl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_LVL) |=> (fifo_lvl == $past(wdata[5:0])));

    // R3: a flag write leaves every configuration register unchanged
    a_r3_flag_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_FLAG) |=> ($stable(baud_int) && $stable(line_ctrl)
            && $stable(ctrl) && $stable(fifo_lvl) && $stable(baud_frac)));
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_regs_pkg::*;
#(
    parameter int ST_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [IRQ_W-1:0] wdata,
    input  logic             tx_evt,
    input  logic             rx_evt,
    input  logic             pop_evt,
    input  logic [ST_W-1:0]  head_err,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] mask,
    output logic [ST_W-1:0]  rxstat,
    output logic             irq
);
    logic [IRQ_W-1:0] set_bits;
    logic [IRQ_W-1:0] clr_bits;

    always_comb begin
        set_bits = '0;
        set_bits[IRQ_TX] = tx_evt;
        set_bits[IRQ_RX] = rx_evt;
        clr_bits = (wr_en && sel == SEL_CLR) ? wdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw    <= '0;
            mask   <= '0;
            rxstat <= '0;
        end else begin
            raw <= (raw & ~clr_bits) | set_bits;
            if (wr_en && sel == SEL_MASK) mask <= wdata;
            if (pop_evt) rxstat <= head_err;
            else if (wr_en && sel == SEL_RXSTAT) rxstat <= '0;
        end
    end

    assign irq = |(raw & mask);

    // R6: a transmit event is visible in raw status on the next cycle
    a_r6_tx_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
        tx_evt |=> raw[IRQ_TX]);

    // R10: a status write clears the latched error bits
    a_r10_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_RXSTAT && !pop_evt) |=> (rxstat == '0));

    // R12: interrupt clear removes the written bits unless an event sets them again
    a_r12_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CLR && wdata[IRQ_TX] && !tx_evt) |=> !raw[IRQ_TX]);
endmodule

// File: rtl/uart_reg_frontend.sv
module uart_reg_frontend
    import uart_regs_pkg::*;
#(
    parameter int ID_VARIANT = 0,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int ENTRY_W    = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               tx_push,
    output logic [7:0]         tx_byte,
    output logic               rx_push,
    output logic [ENTRY_W-1:0] rx_entry,
    output logic               rx_flush,
    output logic               rx_pop,
    input  logic [ENTRY_W-1:0] rx_head,
    input  logic               rx_empty,
    input  logic               rx_full,
    input  logic               tx_full,
    input  logic               tx_empty,
    output logic [15:0]        baud_int,
    output logic [5:0]         baud_frac,
    output logic [7:0]         line_ctrl,
    output logic [15:0]        ctrl,
    output logic [5:0]         fifo_lvl,
    output logic [7:0]         irda_div,
    output logic [2:0]         dma_ctrl,
    output logic               irq
);
    localparam int ST_W = ENTRY_W - 8;
    localparam logic [ENTRY_W-1:0] BRK_ENTRY = ENTRY_W'(1) << BRK_BIT;

    reg_sel_e         sel;
    logic [2:0]       id_idx;
    logic [7:0]       id_byte;
    logic             brk_on;
    logic             fen_flip;
    logic             loop_on;
    logic             data_rd;
    logic [IRQ_W-1:0] raw;
    logic [IRQ_W-1:0] mask;
    logic [ST_W-1:0]  rxstat;
    logic [DATA_W-1:0] rd_mux;
    logic             unused_hi;

    assign unused_hi = ^bus_wdata[DATA_W-1:16];

    uart_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .sel    (sel),
        .id_idx (id_idx)
    );

    uart_id_rom #(.VARIANT(ID_VARIANT)) u_rom (
        .idx     (id_idx),
        .id_byte (id_byte)
    );

    uart_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .sel       (sel),
        .wdata     (bus_wdata[15:0]),
        .baud_int  (baud_int),
        .baud_frac (baud_frac),
        .line_ctrl (line_ctrl),
        .ctrl      (ctrl),
        .fifo_lvl  (fifo_lvl),
        .irda_div  (irda_div),
        .dma_ctrl  (dma_ctrl),
        .brk_on    (brk_on),
        .fen_flip  (fen_flip)
    );

    assign loop_on  = ctrl[CTRL_LOOP];
    assign tx_push  = bus_wr && (sel == SEL_DATA);
    assign tx_byte  = bus_wdata[7:0];
    assign rx_push  = loop_on && (tx_push || brk_on);
    assign rx_entry = brk_on ? BRK_ENTRY : {{(ENTRY_W-8){1'b0}}, tx_byte};
    assign rx_flush = fen_flip;
    assign data_rd  = bus_rd && (sel == SEL_DATA);
    assign rx_pop   = data_rd && !rx_empty;

    uart_irq_status #(.ST_W(ST_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .sel      (sel),
        .wdata    (bus_wdata[IRQ_W-1:0]),
        .tx_evt   (tx_push),
        .rx_evt   (rx_push),
        .pop_evt  (data_rd),
        .head_err (rx_head[ENTRY_W-1:8]),
        .raw      (raw),
        .mask     (mask),
        .rxstat   (rxstat),
        .irq      (irq)
    );

    always_comb begin
        unique case (sel)
            SEL_DATA:   rd_mux = DATA_W'(rx_head);
            SEL_RXSTAT: rd_mux = DATA_W'(rxstat);
            SEL_FLAG:   rd_mux = DATA_W'({tx_empty, rx_full, tx_full, rx_empty, 4'b0000});
            SEL_IRDA:   rd_mux = DATA_W'(irda_div);
            SEL_BINT:   rd_mux = DATA_W'(baud_int);
            SEL_BFRAC:  rd_mux = DATA_W'(baud_frac);
            SEL_LINE:   rd_mux = DATA_W'(line_ctrl);
            SEL_CTRL:   rd_mux = DATA_W'(ctrl);
            SEL_LVL:    rd_mux = DATA_W'(fifo_lvl);
            SEL_MASK:   rd_mux = DATA_W'(mask);
            SEL_RAW:    rd_mux = DATA_W'(raw);
            SEL_MSTAT:  rd_mux = DATA_W'(raw & mask);
            SEL_DMA:    rd_mux = DATA_W'(dma_ctrl);
            SEL_ID:     rd_mux = DATA_W'(id_byte);
            default:    rd_mux = '0;
        endcase
    end

    assign bus_rdata = bus_rd ? rd_mux : '0;

    // R10: the receive buffer is popped only by a data read with data present
    a_r10_pop_gated: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (bus_rd && !rx_empty));

    // R7: receive pushes only happen in loopback
    a_r7_push_loop_only: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> ctrl[CTRL_LOOP]);

    // R9: a flush is followed by a changed FIFO-enable bit
    a_r9_flush_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (line_ctrl[LINE_FEN] != $past(line_ctrl[LINE_FEN])));

    // R1: read and write strobes never coincide
    a_r1_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
endmodule

// File: tb/uart_reg_frontend_test.sv
module uart_reg_frontend_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [11:0] rx_head = '0;
    logic        rx_empty = 1'b1;
    logic        rx_full = 1'b0;
    logic        tx_full = 1'b0;
    logic        tx_empty = 1'b1;

    logic [31:0] bus_rdata, b_rdata;
    logic        tx_push, b_tx_push;
    logic [7:0]  tx_byte, b_tx_byte;
    logic        rx_push, b_rx_push;
    logic [11:0] rx_entry, b_rx_entry;
    logic        rx_flush, b_rx_flush;
    logic        rx_pop, b_rx_pop;
    logic [15:0] baud_int, b_baud_int;
    logic [5:0]  baud_frac, b_baud_frac;
    logic [7:0]  line_ctrl, b_line_ctrl;
    logic [15:0] ctrl, b_ctrl;
    logic [5:0]  fifo_lvl, b_fifo_lvl;
    logic [7:0]  irda_div, b_irda_div;
    logic [2:0]  dma_ctrl, b_dma_ctrl;
    logic        irq, b_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic        s_tx_push, s_rx_push, s_rx_flush, s_rx_pop;
    logic [7:0]  s_tx_byte;
    logic [11:0] s_rx_entry;
    logic [31:0] s_rdata_b;

    uart_reg_frontend #(.ID_VARIANT(0)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_push(tx_push), .tx_byte(tx_byte), .rx_push(rx_push),
        .rx_entry(rx_entry), .rx_flush(rx_flush), .rx_pop(rx_pop),
        .rx_head(rx_head), .rx_empty(rx_empty), .rx_full(rx_full),
        .tx_full(tx_full), .tx_empty(tx_empty), .baud_int(baud_int),
        .baud_frac(baud_frac), .line_ctrl(line_ctrl), .ctrl(ctrl),
        .fifo_lvl(fifo_lvl), .irda_div(irda_div), .dma_ctrl(dma_ctrl),
        .irq(irq)
    );

    uart_reg_frontend #(.ID_VARIANT(1)) uut_b (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(b_rdata),
        .tx_push(b_tx_push), .tx_byte(b_tx_byte), .rx_push(b_rx_push),
        .rx_entry(b_rx_entry), .rx_flush(b_rx_flush), .rx_pop(b_rx_pop),
        .rx_head(rx_head), .rx_empty(rx_empty), .rx_full(rx_full),
        .tx_full(tx_full), .tx_empty(tx_empty), .baud_int(b_baud_int),
        .baud_frac(b_baud_frac), .line_ctrl(b_line_ctrl), .ctrl(b_ctrl),
        .fifo_lvl(b_fifo_lvl), .irda_div(b_irda_div), .dma_ctrl(b_dma_ctrl),
        .irq(b_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        s_tx_push = tx_push; s_tx_byte = tx_byte; s_rx_push = rx_push;
        s_rx_entry = rx_entry; s_rx_flush = rx_flush;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata; s_rdata_b = b_rdata; s_rx_pop = rx_pop;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(12'h034, v); check("R4 level select reset", v, 32'h12);
        rd(12'h024, v); check("R4 integer divisor reset", v, 0);
        rd(12'h028, v); check("R4 fractional divisor reset", v, 0);
        rd(12'h02C, v); check("R4 line control reset", v, 0);
        rd(12'h030, v); check("R4 control reset", v, 0);
        rd(12'h038, v); check("R4 mask reset", v, 0);
        rd(12'h03C, v); check("R4 raw status reset", v, 0);
        rd(12'h048, v); check("R4 dma reset", v, 0);
        check("R4 irq reset", irq, 0);
        check("R13 fifo_lvl output reset", fifo_lvl, 32'h12);
    endtask

    task automatic t_masks();
        logic [31:0] v;
        wr(12'h024, 32'hABCD1234); rd(12'h024, v); check("R5 integer divisor mask", v, 32'h1234);
        wr(12'h028, 32'hFFFFFFFF); rd(12'h028, v); check("R5 fractional divisor mask", v, 32'h3F);
        wr(12'h020, 32'h000001A5); rd(12'h020, v); check("R5 infrared divisor mask", v, 32'hA5);
        wr(12'h048, 32'h0000000F); rd(12'h048, v); check("R5 dma mask", v, 32'h7);
        wr(12'h034, 32'h0000002D); rd(12'h034, v); check("R1 level select rw", v, 32'h2D);
        check("R13 baud_int output", baud_int, 32'h1234);
        check("R13 baud_frac output", baud_frac, 32'h3F);
        check("R13 irda_div output", irda_div, 32'hA5);
        check("R13 dma_ctrl output", dma_ctrl, 32'h7);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(12'h04C, 32'hFFFF); rd(12'h04C, v); check("R3 unmapped reads zero", v, 0);
        rd(12'h800, v); check("R3 unmapped high word reads zero", v, 0);
        wr(12'h025, 32'h5555); rd(12'h024, v); check("R1 misaligned write ignored", v, 32'h1234);
        rd(12'h025, v); check("R1 misaligned read zero", v, 0);
        rd(12'h044, v); check("R3 interrupt clear reads zero", v, 0);
    endtask

    task automatic t_flags();
        logic [31:0] v;
        rx_empty = 1'b1; tx_full = 1'b0; rx_full = 1'b1; tx_empty = 1'b0;
        rd(12'h018, v); check("R11 flag layout a", v, 32'h50);
        rx_empty = 1'b0; tx_full = 1'b1; rx_full = 1'b0; tx_empty = 1'b1;
        rd(12'h018, v); check("R11 flag layout b", v, 32'hA0);
        wr(12'h018, 32'hFFFFFFFF);
        rd(12'h024, v); check("R3 flag write leaves divisor", v, 32'h1234);
        rd(12'h02C, v); check("R3 flag write leaves line control", v, 0);
        rd(12'h030, v); check("R3 flag write leaves control", v, 0);
        rd(12'h018, v); check("R3 flag still from inputs", v, 32'hA0);
        rx_empty = 1'b1; tx_full = 1'b0; rx_full = 1'b0; tx_empty = 1'b1;
    endtask

    task automatic t_id();
        logic [7:0] tab_a [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        logic [7:0] tab_b [8] = '{8'h11, 8'h00, 8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        logic [31:0] v;
        for (int i = 0; i < 8; i++) begin
            rd(12'hFE0 + 12'(4*i), v);
            check($sformatf("R2 variant 0 byte %0d", i), v, 32'(tab_a[i]));
            check($sformatf("R2 variant 1 byte %0d", i), s_rdata_b, 32'(tab_b[i]));
        end
        wr(12'hFE0, 32'hFF);
        rd(12'hFE0, v); check("R2 write to id ignored", v, 32'h11);
        rd(12'hFE1, v); check("R1 misaligned id reads zero", v, 0);
    endtask

    task automatic t_tx_irq();
        logic [31:0] v;
        wr(12'h038, 32'h20);
        rd(12'h038, v); check("R12 mask rw", v, 32'h20);
        check("R12 irq low before event", irq, 0);
        wr(12'h000, 32'h1C3);
        check("R6 tx_push on data write", s_tx_push, 1);
        check("R6 tx_byte low bits", s_tx_byte, 32'hC3);
        check("R7 no rx_push without loopback", s_rx_push, 0);
        check("R12 irq after tx", irq, 1);
        rd(12'h03C, v); check("R6 raw tx bit", v, 32'h20);
        rd(12'h040, v); check("R12 masked status", v, 32'h20);
        wr(12'h044, 32'h20);
        check("R12 irq cleared", irq, 0);
        rd(12'h03C, v); check("R12 raw cleared", v, 0);
    endtask

    task automatic t_loop();
        logic [31:0] v;
        wr(12'h030, 32'h0081);
        check("R13 ctrl output", ctrl, 32'h81);
        wr(12'h000, 32'h5A);
        check("R7 loopback push", s_rx_push, 1);
        check("R7 loopback entry", s_rx_entry, 32'h05A);
        check("R6 tx_push in loopback", s_tx_push, 1);
        rd(12'h03C, v); check("R12 raw rx and tx bits", v, 32'h30);
        wr(12'h044, 32'h7FF);
    endtask

    task automatic t_break();
        logic [31:0] v;
        wr(12'h02C, 32'h01);
        check("R8 break rise pushes", s_rx_push, 1);
        check("R8 break entry", s_rx_entry, 32'h400);
        check("R9 no flush on break", s_rx_flush, 0);
        wr(12'h02C, 32'h01);
        check("R8 break held no push", s_rx_push, 0);
        wr(12'h02C, 32'h00);
        check("R8 break fall no push", s_rx_push, 0);
        wr(12'h030, 32'h0000);
        wr(12'h02C, 32'h01);
        check("R8 break without loopback no push", s_rx_push, 0);
        check("R13 line_ctrl output", line_ctrl, 32'h01);
        wr(12'h02C, 32'h00);
        rd(12'h03C, v); check("R12 raw after break only rx", v, 32'h10);
        wr(12'h044, 32'h7FF);
    endtask

    task automatic t_flush();
        wr(12'h02C, 32'h10); check("R9 enable flush", s_rx_flush, 1);
        wr(12'h02C, 32'h10); check("R9 unchanged no flush", s_rx_flush, 0);
        wr(12'h02C, 32'h00); check("R9 disable flush", s_rx_flush, 1);
        wr(12'h030, 32'h10); check("R9 other write no flush", s_rx_flush, 0);
    endtask

    task automatic t_rx_read();
        logic [31:0] v;
        rx_empty = 1'b0; rx_head = 12'h3A7;
        rd(12'h000, v);
        check("R10 data read value", v, 32'h3A7);
        check("R10 pop with data", s_rx_pop, 1);
        rd(12'h004, v); check("R10 status latched", v, 32'h3);
        wr(12'h004, 32'h0); rd(12'h004, v); check("R10 status cleared", v, 0);
        rx_empty = 1'b1; rx_head = 12'h0FF;
        rd(12'h000, v);
        check("R10 no pop when empty", s_rx_pop, 0);
        check("R10 empty read value", v, 32'hFF);
        rd(12'h004, v); check("R10 status from empty read", v, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masks();
        t_unmapped();
        t_flags();
        t_id();
        t_tx_irq();
        t_loop();
        t_break();
        t_flush();
        t_rx_read();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule